// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for a pin count that is a multiple of 32 (64 or 96). The pins are split into 32-pin banks. Every feature of the controller is a group of registers, one 32-bit word for each bank. The features are a synchronised level readback, a direction control, separate write-one ports that raise or lower the output latch, per-pin rising and falling edge enables, and a sticky edge-status word that is cleared by writing one.

Software reaches the registers through a simple single-cycle 32-bit read/write bus. Read data comes back one cycle after the access. Pad inputs pass through a two-flop synchroniser before they are read or checked for edges. A single registered interrupt line goes high whenever any status bit in any bank is pending. Each pin also has an output-enable line that follows its direction bit.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The register groups use group indices 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable and 6 edge status. A group's word for a bank sits at byte address group*NBANK*4 + bank*4, where NBANK = NUM_PINS/32. Pin p is bit p mod 32 of the word for bank p/32. The two low address bits are ignored.
- R2: A read of the level group returns the pad value after two register stages, for every pin and whatever its direction.
- R3: The direction group can be read and written. A bit of 1 makes the pin an output, so pad_oe for that pin is 1. A bit of 0 makes the pin an input.
- R4: Writing to the set group raises the output latch (pad_out) of every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R5: Writing to the clear group lowers the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R6: Reads of the set and clear groups return zero. Accesses at word indices of 7*NBANK or above read zero and change no state.
- R7: When a pin's rising enable is 1, a 0-to-1 change of its synchronised input sets its status bit.
- R8: When a pin's falling enable is 1, a 1-to-0 change sets its status bit. With both enables set, either edge sets it.
- R9: An edge whose matching enable is 0 leaves the status bit unchanged.
- R10: Writing the status group clears only the bits written as 1. Bits written as 0 are left as they are.
- R11: If a qualifying edge and a write-one-clear reach the same status bit in the same cycle, the bit stays set.
- R12: irq is the OR of all status bits, delayed by one register. It stays low while no status bit is set.
- R13: After reset, direction, output latch, both enables, status and irq are all zero.
- R14: Read data appears on bus_rdata in the cycle after the read is accepted. It is zero after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output latch value |
| pad_oe | output | NUM_PINS | Output enable, one per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bound checker checks the status-word rules on every cycle:
- a status bit only rises where an enabled edge occurred;
- a status bit only falls under a clear mask;
- an edge that meets a clear wins.

It also checks on every cycle that the output latch moves only under a set or clear strobe and in the written direction, and that irq tracks pending status. Only the bench scenarios can show that the address arithmetic places each group and bank correctly, and that the synchroniser delay and read latency are as stated. They also show that the edge-versus-clear collision holds when it is driven through the pads and the bus with exact cycle alignment.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W     = 32;
  localparam int NUM_GROUPS = 7;

  // Group index order is part of the address map (group * NBANK words).
  typedef enum logic [2:0] {
    GRP_LEVEL = 3'd0,
    GRP_DIR   = 3'd1,
    GRP_SET   = 3'd2,
    GRP_CLR   = 3'd3,
    GRP_RISE  = 3'd4,
    GRP_FALL  = 3'd5,
    GRP_STAT  = 3'd6
  } grp_e;

  // Word index -> group number (may exceed NUM_GROUPS-1 when out of range).
  function automatic int unsigned group_of(input int unsigned widx,
                                           input int unsigned nbank);
    return widx / nbank;
  endfunction

  // Word index -> bank number inside its group.
  function automatic int unsigned bank_of(input int unsigned widx,
                                          input int unsigned nbank);
    return widx % nbank;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_regdec.sv
module gpio_regdec
  import gpio_bank_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_GROUPS-1:0] grp_hit,
  output logic [NBANK-1:0]      bank_sel
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  int unsigned       grp_n, bank_n;
  logic              in_range;

  assign widx = bus_addr[ADDR_W-1:2];

  always_comb begin
    grp_n    = group_of(32'(widx), 32'(NBANK));
    bank_n   = bank_of(32'(widx), 32'(NBANK));
    in_range = grp_n < 32'(NUM_GROUPS);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = in_range && (grp_n == 32'(g));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_sel[b] = (bank_n == 32'(b));
  end

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] status,
  output logic             irq
);

  assign edge_hit = (rise & rise_en) | (fall & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      // A new edge overrides a clear of the same bit.
      status <= (status & ~clr_mask) | edge_hit;
      irq    <= |status;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);

  localparam int NBANK = NUM_PINS / WORD_W;

  logic [NUM_GROUPS-1:0] grp_hit, wr_grp;
  logic [NBANK-1:0]      bank_sel;
  logic [NUM_PINS-1:0]   level, rise, fall, edge_hit, edge_status;
  logic [NUM_PINS-1:0]   dir_q, out_q, rise_en_q, fall_en_q;
  logic [NUM_PINS-1:0]   out_set_mask, out_clr_mask, stat_clr_mask;
  logic [NUM_PINS-1:0]   rd_vec;
  logic [WORD_W-1:0]     rd_word, rdata_q;

  gpio_regdec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .grp_hit  (grp_hit),
    .bank_sel (bank_sel)
  );

  gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  assign wr_grp = grp_hit & {NUM_GROUPS{bus_en & bus_we}};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * WORD_W;
    logic bank_wr;
    assign bank_wr = bank_sel[b];

    assign out_set_mask[LO +: WORD_W]  = (wr_grp[GRP_SET]  && bank_wr) ? bus_wdata : '0;
    assign out_clr_mask[LO +: WORD_W]  = (wr_grp[GRP_CLR]  && bank_wr) ? bus_wdata : '0;
    assign stat_clr_mask[LO +: WORD_W] = (wr_grp[GRP_STAT] && bank_wr) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[LO +: WORD_W]     <= '0;
        out_q[LO +: WORD_W]     <= '0;
        rise_en_q[LO +: WORD_W] <= '0;
        fall_en_q[LO +: WORD_W] <= '0;
      end else begin
        if (wr_grp[GRP_DIR] && bank_wr)  dir_q[LO +: WORD_W]     <= bus_wdata;
        if (wr_grp[GRP_RISE] && bank_wr) rise_en_q[LO +: WORD_W] <= bus_wdata;
        if (wr_grp[GRP_FALL] && bank_wr) fall_en_q[LO +: WORD_W] <= bus_wdata;
        out_q[LO +: WORD_W] <= (out_q[LO +: WORD_W] | out_set_mask[LO +: WORD_W])
                               & ~out_clr_mask[LO +: WORD_W];
      end
    end
  end

  gpio_edge_status #(.WIDTH(NUM_PINS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .fall     (fall),
    .rise_en  (rise_en_q),
    .fall_en  (fall_en_q),
    .clr_mask (stat_clr_mask),
    .edge_hit (edge_hit),
    .status   (edge_status),
    .irq      (irq)
  );

  // Read path: pick the feature vector, then the bank word.
  always_comb begin
    rd_vec = '0;
    if (grp_hit[GRP_LEVEL]) rd_vec = level;
    if (grp_hit[GRP_DIR])   rd_vec = dir_q;
    if (grp_hit[GRP_RISE])  rd_vec = rise_en_q;
    if (grp_hit[GRP_FALL])  rd_vec = fall_en_q;
    if (grp_hit[GRP_STAT])  rd_vec = edge_status;
    rd_word = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_sel[b]) rd_word = rd_word | rd_vec[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= (bus_en && !bus_we) ? rd_word : '0;
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int NUM_PINS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] edge_status,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic [NUM_PINS-1:0] stat_clr_mask,
  input logic [NUM_PINS-1:0] out_set_mask,
  input logic [NUM_PINS-1:0] out_clr_mask,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                irq
);

  // R7 R8 R9: a status bit rises only where an enabled edge was seen
  a_r9_no_spurious_status: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_status & ~$past(edge_status) & ~$past(edge_hit)) == '0));

  // R10: a status bit falls only where a one was written to clear it
  a_r10_clear_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_status) & ~edge_status & ~$past(stat_clr_mask)) == '0));

  // R11: edge meeting a clear leaves the bit set
  a_r11_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_hit & stat_clr_mask)) |=>
      ((edge_status & $past(edge_hit & stat_clr_mask)) == $past(edge_hit & stat_clr_mask)));

  // R4 R5: output latch is stable with no set/clear strobe
  a_r4_out_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_set_mask == '0 && out_clr_mask == '0) |=> $stable(pad_out));

  // R4: bits written to the set port end high
  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (out_set_mask != '0 && out_clr_mask == '0) |=>
      ((pad_out & $past(out_set_mask)) == $past(out_set_mask)));

  // R5: bits written to the clear port end low
  a_r5_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (out_clr_mask != '0) |=> ((pad_out & $past(out_clr_mask)) == '0));

  // R12: irq only rises after some status bit was pending
  a_r12_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(edge_status != '0));

  // R12: irq follows a pending status bit
  a_r12_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_status != '0) |=> irq);

endmodule

bind gpio_bank_ctrl gpio_bank_checker #(.NUM_PINS(NUM_PINS)) u_gpio_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .edge_status   (edge_status),
  .edge_hit      (edge_hit),
  .stat_clr_mask (stat_clr_mask),
  .out_set_mask  (out_set_mask),
  .out_clr_mask  (out_clr_mask),
  .pad_out       (pad_out),
  .irq           (irq)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 64;
  localparam int NB         = NP / 32;
  localparam int AW         = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // R1: bench-side address arithmetic
  function automatic logic [AW-1:0] reg_addr(input int grp, input int bank);
    return AW'((grp * NB + bank) * 4);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // Driver: issue a read and push the expected word into the scoreboard.
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic drive_pad(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (5) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= rst_n && bus_en && !bus_we;

  // Monitor (R14): read data is due in the cycle after the access.
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R14 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 pad_oe",  64'(pad_oe), 64'h0);
    chk("R13 pad_out", 64'(pad_out), 64'h0);
    chk("R13 irq",     64'(irq), 64'h0);
    chk("R14 idle rdata", 64'(bus_rdata), 64'h0);
    for (int b = 0; b < NB; b++) begin
      rd(reg_addr(1, b), 32'h0, "R13 dir");
      rd(reg_addr(4, b), 32'h0, "R13 rise_en");
      rd(reg_addr(5, b), 32'h0, "R13 fall_en");
      rd(reg_addr(6, b), 32'h0, "R13 status");
    end

    // R3 direction, R1 bank placement
    wr(reg_addr(1, 0), 32'h0000_00FF);
    wr(reg_addr(1, 1), 32'hA5A5_0000);
    rd(reg_addr(1, 0), 32'h0000_00FF, "R3 dir bank0");
    rd(reg_addr(1, 1), 32'hA5A5_0000, "R1 R3 dir bank1");
    chk("R3 pad_oe", 64'(pad_oe), 64'hA5A5_0000_0000_00FF);
    wr(reg_addr(1, 0) | AW'(2), 32'h0000_00F0);  // low address bits ignored (R1)
    rd(reg_addr(1, 0), 32'h0000_00F0, "R1 low addr bits ignored");

    // R4 set, R5 clear
    wr(reg_addr(2, 0), 32'h0000_0F0F);
    chk("R4 set bank0", 64'(pad_out), 64'h0000_0000_0000_0F0F);
    wr(reg_addr(2, 1), 32'h8000_0001);
    chk("R4 set bank1 keeps bank0", 64'(pad_out), 64'h8000_0001_0000_0F0F);
    wr(reg_addr(3, 0), 32'h0000_0003);
    chk("R5 clear bank0", 64'(pad_out), 64'h8000_0001_0000_0F0C);
    wr(reg_addr(3, 1), 32'h8000_0000);
    chk("R5 clear bank1", 64'(pad_out), 64'h0000_0001_0000_0F0C);

    // R6 set/clear read zero; out-of-range access
    rd(reg_addr(2, 0), 32'h0, "R6 set reads zero");
    rd(reg_addr(3, 1), 32'h0, "R6 clear reads zero");
    wr(reg_addr(7, 0), 32'hFFFF_FFFF);
    wr(reg_addr(7, 1), 32'hFFFF_FFFF);
    chk("R6 oob write pad_out", 64'(pad_out), 64'h0000_0001_0000_0F0C);
    chk("R6 oob write pad_oe",  64'(pad_oe),  64'hA5A5_0000_0000_00F0);
    rd(reg_addr(7, 0), 32'h0, "R6 oob read");
    rd(reg_addr(4, 0), 32'h0, "R6 oob write left rise_en");

    // R2 level readback regardless of direction
    drive_pad(64'hDEAD_BEEF_0123_4567);
    rd(reg_addr(0, 0), 32'h0123_4567, "R2 level bank0");
    rd(reg_addr(0, 1), 32'hDEAD_BEEF, "R2 level bank1");
    rd(reg_addr(6, 0), 32'h0, "R9 no enables no status");
    drive_pad(64'h0);
    rd(reg_addr(6, 1), 32'h0, "R9 no enables no status bank1");
    chk("R12 irq idle", 64'(irq), 64'h0);

    // Enables: pin0 rise, pin2 both, pin33 fall
    wr(reg_addr(4, 0), 32'h0000_0005);
    wr(reg_addr(5, 0), 32'h0000_0004);
    wr(reg_addr(5, 1), 32'h0000_0002);

    // R7 rising edge on pin0
    drive_pad(64'h1);
    rd(reg_addr(6, 0), 32'h1, "R7 rise pin0");
    chk("R12 irq set", 64'(irq), 64'h1);
    // R9 falling edge on pin0 without fall enable (bit stays, not re-set)
    drive_pad(64'h0);
    wr(reg_addr(6, 0), 32'h0000_0000);
    rd(reg_addr(6, 0), 32'h1, "R10 zero write keeps");
    wr(reg_addr(6, 0), 32'h0000_0001);
    rd(reg_addr(6, 0), 32'h0, "R9 R10 cleared, fall ignored");
    repeat (2) @(negedge clk);
    chk("R12 irq cleared", 64'(irq), 64'h0);

    // R8 both edges on pin2
    drive_pad(64'h4);
    rd(reg_addr(6, 0), 32'h4, "R8 both-en rise pin2");
    wr(reg_addr(6, 0), 32'h4);
    drive_pad(64'h0);
    rd(reg_addr(6, 0), 32'h4, "R8 both-en fall pin2");
    wr(reg_addr(6, 0), 32'h4);

    // R8 fall-only on pin33: rise ignored, fall caught
    drive_pad(64'h2_0000_0000);
    rd(reg_addr(6, 1), 32'h0, "R9 rise ignored pin33");
    drive_pad(64'h0);
    rd(reg_addr(6, 1), 32'h2, "R8 fall pin33");
    chk("R12 irq bank1", 64'(irq), 64'h1);
    wr(reg_addr(6, 1), 32'h2);

    // R11 edge coinciding with clear on pin2
    drive_pad(64'h4);
    @(negedge clk);
    pad_in = 64'h0;
    @(posedge clk);
    @(posedge clk);
    wr(reg_addr(6, 0), 32'h4);  // captured on the edge-detect cycle
    rd(reg_addr(6, 0), 32'h4, "R11 edge beats clear");
    wr(reg_addr(6, 0), 32'h4);
    rd(reg_addr(6, 0), 32'h0, "R10 later clear works");

    repeat (4) @(negedge clk);
    chk("R14 scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule